// File: doc/BRIEF.md
# DMA Address Remapping Unit

This block sits between a teletext DMA master and the CPU bus. It turns each 20-bit DMA address into a CPU bus address. It does this by comparing the upper twelve address bits against four programmable windows. Each window holds three 12-bit values:

- a mask, which selects which address bits take part in the comparison;
- a compare value, which the masked bits must equal;
- a replacement value, which is substituted for bits 19:8 when the window is chosen.

Each window also has its own enable. A mode register holds a global enable that gates every request onto the CPU bus.

The address path is purely combinational. The outgoing address follows the incoming one within the same cycle. All settings are loaded through a byte-wide, write-only register port and held in flops. When several windows match, the lowest-numbered one is used. An address that hits no enabled window goes out unchanged except for bit 19, which is forced to 1.

Top module: `dma_remap_unit`

## Requirements
- R1: After reset, every window's mask, compare and replacement value is 0xFFF. The mode register is 0x00, so no window is enabled and `cpu_req_valid` stays low.
- R2: An enabled window matches when (dma_addr[19:8] AND mask) equals its compare value.
- R3: When a window is selected, cpu_addr[19:8] equals that window's replacement value, and cpu_addr[7:0] equals dma_addr[7:0].
- R4: Among matching enabled windows, window 1 has the highest priority, then window 2, then 3, then 4.
- R5: If no enabled window matches, cpu_addr equals dma_addr with bit 19 set to 1.
- R6: A window whose enable bit is 0 never matches, whatever its register contents.
- R7: While mode bit 7 (global enable) is 0, `cpu_req_valid` is low. Configuration writes are still taken and are used once the enable is set.
- R8: Register layout, for window n = 0..3 at byte offset from the base 0x1E00:
  - mask low at 0x00+n and mask high at 0x04+n;
  - compare low at 0x08+n and compare high at 0x0C+n;
  - replacement low at 0x10+n and replacement high at 0x14+n;
  - mode at 0x18.
  A low byte carries bits 15:8 in data bits 7:0. A high byte carries bits 19:16 in data bits 3:0, and its data bits 7:4 are ignored. In the mode register, bit 7 is the global enable and bit k (k = 0..3) enables window k+1.
- R9: Writes to addresses below the base or above base+0x18 change no setting.
- R10: When the global enable is 1, `cpu_req_valid` equals `dma_req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 16 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| dma_req_valid | input | 1 | DMA master request valid |
| dma_addr | input | 20 | DMA master address |
| cpu_req_valid | output | 1 | Request valid towards the CPU bus |
| cpu_addr | output | 20 | Translated CPU bus address |

## Verification
The reset contents are checked by clearing only one compare byte. The resulting hit then reveals the reset replacement value, and a near-miss reveals the reset mask.

A single window with a partial mask is tried with these patterns:
- addresses that differ only in masked-out bits, which must still hit;
- an address that differs in a masked-in bit, which must fall through;
- varied low bytes, which show that bits 7:0 pass untouched.

Four windows that all match every address are enabled in several combinations. Each combination exposes a distinct replacement value, which separates every pair in the priority order.

Writes made while the global enable is off, high-byte writes with junk in bits 7:4, and writes just outside the register range show whether the decoder keeps or drops each byte.

// File: rtl/dma_remap_pkg.sv
package dma_remap_pkg;
  localparam int NUM_WIN  = 4;
  localparam int ADDR_W   = 20;
  localparam int SEG_LO   = 8;
  localparam int SEG_W    = ADDR_W - SEG_LO;
  localparam int BYTE_W   = 8;
  localparam int HI_W     = SEG_W - BYTE_W;
  localparam int CFG_AW   = 16;

  typedef logic [SEG_W-1:0] seg_t;

  typedef struct packed {
    seg_t mask;
    seg_t cmp;
    seg_t map;
  } win_cfg_t;

  // register groups, selected by offset bits 4:2
  typedef enum logic [2:0] {
    GRP_MASK_LO = 3'd0,
    GRP_MASK_HI = 3'd1,
    GRP_CMP_LO  = 3'd2,
    GRP_CMP_HI  = 3'd3,
    GRP_MAP_LO  = 3'd4,
    GRP_MAP_HI  = 3'd5,
    GRP_MODE    = 3'd6
  } grp_e;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import dma_remap_pkg::*;
#(
  parameter logic [CFG_AW-1:0] BASE_ADDR = 16'h1E00
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [CFG_AW-1:0]         addr,
  input  logic [BYTE_W-1:0]         wdata,
  output win_cfg_t [NUM_WIN-1:0]    cfg_o,
  output logic [NUM_WIN-1:0]        win_en_o,
  output logic                      glob_en_o
);
  localparam logic [CFG_AW-1:0] LAST_OFF = 16'h0018;

  win_cfg_t [NUM_WIN-1:0] cfg_q, cfg_d;
  logic [NUM_WIN-1:0]     en_q, en_d;
  logic                   glob_q, glob_d;

  logic [CFG_AW-1:0] off;
  logic              in_range;
  logic              wr_en;
  logic [2:0]        grp;
  logic [1:0]        idx;

  assign off      = addr - BASE_ADDR;
  assign in_range = (addr >= BASE_ADDR) && (off <= LAST_OFF);
  assign wr_en    = we && in_range;
  assign grp      = off[4:2];
  assign idx      = off[1:0];

  always_comb begin
    cfg_d  = cfg_q;
    en_d   = en_q;
    glob_d = glob_q;
    if (wr_en) begin
      unique case (grp_e'(grp))
        GRP_MASK_LO: cfg_d[idx].mask[BYTE_W-1:0]     = wdata;
        GRP_MASK_HI: cfg_d[idx].mask[SEG_W-1:BYTE_W] = wdata[HI_W-1:0];
        GRP_CMP_LO:  cfg_d[idx].cmp[BYTE_W-1:0]      = wdata;
        GRP_CMP_HI:  cfg_d[idx].cmp[SEG_W-1:BYTE_W]  = wdata[HI_W-1:0];
        GRP_MAP_LO:  cfg_d[idx].map[BYTE_W-1:0]      = wdata;
        GRP_MAP_HI:  cfg_d[idx].map[SEG_W-1:BYTE_W]  = wdata[HI_W-1:0];
        GRP_MODE: begin
          glob_d = wdata[BYTE_W-1];
          en_d   = wdata[NUM_WIN-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '1;
      en_q   <= '0;
      glob_q <= 1'b0;
    end else if (wr_en) begin
      cfg_q  <= cfg_d;
      en_q   <= en_d;
      glob_q <= glob_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign win_en_o  = en_q;
  assign glob_en_o = glob_q;
endmodule

// File: rtl/remap_window.sv
module remap_window
  import dma_remap_pkg::*;
(
  input  logic  en_i,
  input  seg_t  seg_i,
  input  seg_t  mask_i,
  input  seg_t  cmp_i,
  output logic  hit_o
);
  assign hit_o = en_i && ((seg_i & mask_i) == cmp_i);
endmodule

// File: rtl/remap_priority.sv
module remap_priority
  import dma_remap_pkg::*;
(
  input  logic [NUM_WIN-1:0]        hits_i,
  input  seg_t [NUM_WIN-1:0]        maps_i,
  output logic [NUM_WIN-1:0]        grant_o,
  output logic                      any_o,
  output seg_t                      map_o
);
  // scan from the lowest priority upwards; the last hit written wins
  always_comb begin
    grant_o = '0;
    any_o   = 1'b0;
    map_o   = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        any_o      = 1'b1;
        map_o      = maps_i[i];
      end
    end
  end
endmodule

// File: rtl/dma_remap_unit.sv
module dma_remap_unit
  import dma_remap_pkg::*;
#(
  parameter logic [CFG_AW-1:0] BASE_ADDR = 16'h1E00
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [BYTE_W-1:0]   cfg_wdata,
  input  logic                dma_req_valid,
  input  logic [ADDR_W-1:0]   dma_addr,
  output logic                cpu_req_valid,
  output logic [ADDR_W-1:0]   cpu_addr
);
  logic [1:0]             rst_pipe;
  logic                   rst_sync_n;
  win_cfg_t [NUM_WIN-1:0] win_cfg;
  seg_t     [NUM_WIN-1:0] win_map;
  logic [NUM_WIN-1:0]     win_en;
  logic [NUM_WIN-1:0]     win_hit;
  logic [NUM_WIN-1:0]     grant;
  logic                   glob_en;
  logic                   any_hit;
  seg_t                   sel_map;
  seg_t                   in_seg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  remap_cfg_regs #(.BASE_ADDR(BASE_ADDR)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .cfg_o     (win_cfg),
    .win_en_o  (win_en),
    .glob_en_o (glob_en)
  );

  assign in_seg = dma_addr[ADDR_W-1:SEG_LO];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    remap_window u_win (
      .en_i   (win_en[g]),
      .seg_i  (in_seg),
      .mask_i (win_cfg[g].mask),
      .cmp_i  (win_cfg[g].cmp),
      .hit_o  (win_hit[g])
    );
    assign win_map[g] = win_cfg[g].map;
  end

  remap_priority u_prio (
    .hits_i  (win_hit),
    .maps_i  (win_map),
    .grant_o (grant),
    .any_o   (any_hit),
    .map_o   (sel_map)
  );

  always_comb begin
    if (any_hit) cpu_addr = {sel_map, dma_addr[SEG_LO-1:0]};
    else         cpu_addr = {1'b1, dma_addr[ADDR_W-2:0]};
  end

  assign cpu_req_valid = dma_req_valid && glob_en;
endmodule

// File: rtl/dma_remap_unit_chk.sv
module dma_remap_unit_chk
  import dma_remap_pkg::*;
#(
  parameter logic [CFG_AW-1:0] BASE_ADDR = 16'h1E00
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                cfg_we,
  input logic [CFG_AW-1:0]   cfg_addr,
  input logic [BYTE_W-1:0]   cfg_wdata,
  input logic                dma_req_valid,
  input logic [ADDR_W-1:0]   dma_addr,
  input logic                cpu_req_valid,
  input logic [ADDR_W-1:0]   cpu_addr,
  input logic                glob_en,
  input logic                any_hit,
  input logic [NUM_WIN-1:0]  grant
);
  localparam logic [CFG_AW-1:0] MODE_ADDR = BASE_ADDR + 16'h0018;

  // R3
  low_byte_passes_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cpu_addr[SEG_LO-1:0] == dma_addr[SEG_LO-1:0]);

  // R4
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(grant) && (any_hit == (grant != '0)));

  // R5
  fallthrough_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_hit |-> cpu_addr == {1'b1, dma_addr[ADDR_W-2:0]});

  // R7
  gated_when_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !glob_en |-> !cpu_req_valid);

  // R10
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    glob_en |-> cpu_req_valid == dma_req_valid);

  // R8
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_addr == MODE_ADDR) |=> glob_en == $past(cfg_wdata[BYTE_W-1]));
endmodule

bind dma_remap_unit dma_remap_unit_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .cfg_we        (cfg_we),
  .cfg_addr      (cfg_addr),
  .cfg_wdata     (cfg_wdata),
  .dma_req_valid (dma_req_valid),
  .dma_addr      (dma_addr),
  .cpu_req_valid (cpu_req_valid),
  .cpu_addr      (cpu_addr),
  .glob_en       (glob_en),
  .any_hit       (any_hit),
  .grant         (grant)
);

// File: tb/dma_remap_unit_test.sv
module dma_remap_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h1E00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        dma_req_valid = 1'b0;
  logic [19:0] dma_addr = '0;
  logic        cpu_req_valid;
  logic [19:0] cpu_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_remap_unit uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .dma_req_valid (dma_req_valid),
    .dma_addr      (dma_addr),
    .cpu_req_valid (cpu_req_valid),
    .cpu_addr      (cpu_addr)
  );

  task automatic wr_abs(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [7:0] off, input logic [7:0] d);
    wr_abs(BASE + {8'h00, off}, d);
  endtask

  task automatic set_win(input int n, input logic [11:0] m, input logic [11:0] c,
                         input logic [11:0] p);
    wr(8'(8'h00 + n), m[7:0]);  wr(8'(8'h04 + n), {4'h0, m[11:8]});
    wr(8'(8'h08 + n), c[7:0]);  wr(8'(8'h0C + n), {4'h0, c[11:8]});
    wr(8'(8'h10 + n), p[7:0]);  wr(8'(8'h14 + n), {4'h0, p[11:8]});
  endtask

  task automatic chk(input string req, input logic vin, input logic [19:0] ain,
                     input logic exp_v, input logic [19:0] exp_a);
    dma_req_valid = vin; dma_addr = ain;
    #1;
    checks++;
    if (cpu_req_valid !== exp_v || (exp_v && cpu_addr !== exp_a)) begin
      errors++;
      $display("FAIL %s: in=%05h got valid=%0b addr=%05h expected valid=%0b addr=%05h",
               req, ain, cpu_req_valid, cpu_addr, exp_v, exp_a);
    end
  endtask

  task automatic chk_addr(input string req, input logic [19:0] ain, input logic [19:0] exp_a);
    dma_addr = ain;
    #1;
    checks++;
    if (cpu_addr !== exp_a) begin
      errors++;
      $display("FAIL %s: in=%05h got addr=%05h expected addr=%05h", req, ain, cpu_addr, exp_a);
    end
  endtask

  task automatic t_reset;
    chk("R1", 1'b1, 20'h12345, 1'b0, 20'h0);
    chk_addr("R5", 20'h12345, 20'h92345);
  endtask

  task automatic t_reset_values;
    wr(8'h08, 8'h00);
    wr(8'h18, 8'h81);
    chk("R1", 1'b1, 20'hF0034, 1'b1, 20'hFFF34);
    chk("R1", 1'b1, 20'hF0134, 1'b1, 20'hF0134);
  endtask

  task automatic t_match;
    set_win(1, 12'hF0F, 12'h304, 12'hABC);
    wr(8'h18, 8'h82);
    chk("R2", 1'b1, 20'h3A456, 1'b1, 20'hABC56);
    chk("R2", 1'b1, 20'h3A556, 1'b1, 20'hBA556);
    chk("R3", 1'b1, 20'h30400, 1'b1, 20'hABC00);
    chk("R3", 1'b1, 20'h3F4E7, 1'b1, 20'hABCE7);
  endtask

  task automatic t_priority;
    for (int n = 0; n < 4; n++) set_win(n, 12'h000, 12'h000, 12'(12'h111 * (n + 1)));
    wr(8'h18, 8'h8F); chk("R4", 1'b1, 20'h12345, 1'b1, 20'h11145);
    wr(8'h18, 8'h8E); chk("R4", 1'b1, 20'h12345, 1'b1, 20'h22245);
    wr(8'h18, 8'h8C); chk("R4", 1'b1, 20'h12345, 1'b1, 20'h33345);
    wr(8'h18, 8'h88); chk("R4", 1'b1, 20'h12345, 1'b1, 20'h44445);
    wr(8'h18, 8'h8A); chk("R4", 1'b1, 20'h12345, 1'b1, 20'h22245);
    wr(8'h18, 8'h85); chk("R4", 1'b1, 20'h12345, 1'b1, 20'h11145);
  endtask

  task automatic t_disabled;
    wr(8'h18, 8'h80);
    chk("R6", 1'b1, 20'h12345, 1'b1, 20'h92345);
    chk("R6", 1'b1, 20'h0FFAA, 1'b1, 20'h8FFAA);
  endtask

  task automatic t_global;
    wr(8'h18, 8'h0F);
    chk("R7", 1'b1, 20'h12345, 1'b0, 20'h0);
    wr(8'h10, 8'h77);
    wr(8'h18, 8'h81);
    chk("R7", 1'b1, 20'h12345, 1'b1, 20'h17745);
    chk("R10", 1'b0, 20'h12345, 1'b0, 20'h0);
  endtask

  task automatic t_layout;
    wr(8'h14, 8'hF5);
    chk("R8", 1'b1, 20'h00001, 1'b1, 20'h57701);
    wr(8'h04, 8'hF0);
    chk("R8", 1'b1, 20'hFFF02, 1'b1, 20'h57702);
  endtask

  task automatic t_decode;
    wr_abs(16'h1E19, 8'h00);
    wr_abs(16'h1E1F, 8'h00);
    wr_abs(16'h1D10, 8'h00);
    wr_abs(16'h1F10, 8'h00);
    wr_abs(16'h1DF8, 8'h00);
    chk("R9", 1'b1, 20'h12345, 1'b1, 20'h57745);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_reset_values();
    t_match();
    t_priority();
    t_disabled();
    t_global();
    t_layout();
    t_decode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule